// File: doc/BRIEF.md
# Access Fault Status Recorder and Stack Frame Writer

This block handles an access fault raised either by address translation or by a bus access that hits unmapped space. When the fault strobe arrives it records the access in two places. The first is a packed 16-bit status word built from the access attributes. The second is a fault address register. It then writes an access-error exception frame onto the supervisor stack through a 32-bit write port, issuing one beat per clock. When the last beat has gone out it reports the new stack pointer with a one-cycle completion pulse. Vector fetch and instruction restart belong to the surrounding core.

The frame is 60 bytes: 18 items, each pushed with a pre-decrement of the stack pointer. Ten long words come first. Eight of them are zero, and the last two carry the fault address, in the write-back-3-address slot and then in the fault-address slot. Next come four 16-bit words: three zero write-back status words, then the status word. The faulting effective address follows as a long word. The standard tail ends the frame: the return PC as a long word, then a word holding the frame format (7) in bits 15..12 with the vector offset below it, and then the status register.

A fault that arrives while a frame is still being written is a double fault. The block stops writing and asserts a halt output. Halt stays set until reset.

The controller has four states. ST_IDLE waits. ST_PUSH emits one frame item per cycle. ST_FINISH raises the completion pulse for one cycle. ST_HALT is the double-fault stop. The transitions are as follows:
- IDLE to PUSH on a strobe.
- PUSH to FINISH after item 17.
- PUSH to HALT on a strobe.
- FINISH to PUSH on a strobe.
- FINISH to IDLE otherwise.
- HALT stays in HALT.

Top module: `afw_frame_writer`

## Requirements
- R1: After reset, mem_we, done and halt are low, and status_word and fault_addr are zero.
- R2: A captured status word has bit 10 set. Bit 8 is set for a read (flt_write=0) and clear for a write.
- R3: Status word bits 6..5 encode the access size. flt_size 00 (byte) gives 01, 01 (word) gives 10, and 10 (long) or 11 give 00.
- R4: Status word bits 2..0 are the OR of 4 when flt_super=1 and either 2 (flt_code=1) or 1 (flt_code=0).
- R5: fault_addr holds flt_addr from the strobe that started the current frame.
- R6: The starting stack pointer is sp_in with bit 0 cleared. Each item is written at the stack pointer after it has been lowered by 4 (long) or 2 (word). On done, sp_out equals the even starting value minus 60.
- R7: Items 0 to 9 are long writes. Items 0 to 7 carry zero, and items 8 and 9 carry the fault address.
- R8: Items 10 to 13 are word writes: three zeros, then the status word. Word beats replicate the 16-bit value in both halves of mem_wdata. Their mem_be is 0011 when address bit 1 is 0 and 1100 when it is 1. Long beats use 1111.
- R9: Item 14 is the fault address and item 15 the return PC, both long. Item 16 is the word {4'h7, VEC_OFFSET} (0x7008 by default), and item 17 is the sr_in word.
- R10: The 18 items are written on 18 consecutive cycles, starting the cycle after the strobe. done pulses for exactly one cycle, in the cycle right after the last write.
- R11: A strobe during a frame write stops all writes and raises halt, which holds until reset. The second fault does not change status_word or fault_addr.
- R12: A strobe in the cycle where done is high starts a new frame normally, without halting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_req | input | 1 | Fault strobe, one cycle |
| flt_addr | input | 32 | Faulting access address |
| flt_size | input | 2 | Access size: 00 byte, 01 word, 10 long |
| flt_write | input | 1 | 1 = write access, 0 = read |
| flt_code | input | 1 | 1 = instruction fetch, 0 = data |
| flt_super | input | 1 | 1 = supervisor access |
| sp_in | input | 32 | Current supervisor stack pointer |
| sr_in | input | 16 | Status register to save |
| pc_in | input | 32 | Return PC to save |
| mem_we | output | 1 | Write beat valid |
| mem_addr | output | 32 | Byte address of the beat |
| mem_wdata | output | 32 | Beat data |
| mem_be | output | 4 | Byte enables (lane k = data bits 8k+7..8k) |
| sp_out | output | 32 | Stack pointer after the frame, valid with done |
| done | output | 1 | Frame complete, one-cycle pulse |
| halt | output | 1 | Double fault halt, sticky |
| status_word | output | 16 | Recorded fault status word |
| fault_addr | output | 32 | Recorded fault address |

## Verification
The assertions check, on every cycle, properties that hold whatever frame is in flight. Halt stays set and blocks writes. done is a single-cycle pulse that never overlaps a write, and every write stream ends in either done or halt. Byte enables are always one of the three legal patterns, and a completed frame leaves an even stack pointer with bit 10 of the status word set. Only the bench's scenarios can show the actual contents and order of the 18 items, the address arithmetic from an odd or 2-mod-4 starting pointer, the status word encodings for each size and mode, and the exact cycle at which a double fault cuts the stream.

// File: rtl/afw_pkg.sv
package afw_pkg;

    localparam int DW      = 32;
    localparam int HW      = 16;
    localparam int N_ITEMS = 18;
    localparam int IDX_W   = $clog2(N_ITEMS);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PUSH,
        ST_FINISH,
        ST_HALT
    } afw_state_t;

    typedef enum logic [2:0] {
        SRC_ZERO,
        SRC_FADDR,
        SRC_STAT,
        SRC_PC,
        SRC_FMT,
        SRC_SR
    } afw_src_t;

    typedef struct packed {
        logic     is_word;
        afw_src_t src;
    } afw_item_t;

    // Frame layout, first pushed item at index 0 (highest address).
    function automatic afw_item_t afw_item(input logic [IDX_W-1:0] idx);
        afw_item_t it;
        if (idx < IDX_W'(8))        it = '{1'b0, SRC_ZERO};
        else if (idx < IDX_W'(10))  it = '{1'b0, SRC_FADDR};
        else if (idx < IDX_W'(13))  it = '{1'b1, SRC_ZERO};
        else if (idx == IDX_W'(13)) it = '{1'b1, SRC_STAT};
        else if (idx == IDX_W'(14)) it = '{1'b0, SRC_FADDR};
        else if (idx == IDX_W'(15)) it = '{1'b0, SRC_PC};
        else if (idx == IDX_W'(16)) it = '{1'b1, SRC_FMT};
        else                        it = '{1'b1, SRC_SR};
        return it;
    endfunction

endpackage

// File: rtl/afw_status_pack.sv
module afw_status_pack
    import afw_pkg::*;
(
    input  logic [1:0]    size,
    input  logic          is_write,
    input  logic          is_code,
    input  logic          is_super,
    output logic [HW-1:0] word
);
    logic [1:0] size_fld;
    logic [2:0] mode_fld;

    always_comb begin
        unique case (size)
            2'b00:   size_fld = 2'b01;
            2'b01:   size_fld = 2'b10;
            default: size_fld = 2'b00;
        endcase
        mode_fld = {is_super, is_code, ~is_code};
        word     = '0;
        word[10]  = 1'b1;
        word[8]   = ~is_write;
        word[6:5] = size_fld;
        word[2:0] = mode_fld;
    end
endmodule

// File: rtl/afw_frame_seq.sv
module afw_frame_seq
    import afw_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output logic             is_word,
    output afw_src_t         src,
    output logic             last
);
    afw_item_t it;

    always_comb begin
        it      = afw_item(idx);
        is_word = it.is_word;
        src     = it.src;
        last    = (idx == IDX_W'(N_ITEMS - 1));
    end
endmodule

// File: rtl/afw_frame_writer.sv
module afw_frame_writer
    import afw_pkg::*;
#(
    parameter logic [3:0]  FRAME_FMT  = 4'h7,
    parameter logic [11:0] VEC_OFFSET = 12'h008
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flt_req,
    input  logic [DW-1:0] flt_addr,
    input  logic [1:0]    flt_size,
    input  logic          flt_write,
    input  logic          flt_code,
    input  logic          flt_super,
    input  logic [DW-1:0] sp_in,
    input  logic [HW-1:0] sr_in,
    input  logic [DW-1:0] pc_in,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [3:0]    mem_be,
    output logic [DW-1:0] sp_out,
    output logic          done,
    output logic          halt,
    output logic [HW-1:0] status_word,
    output logic [DW-1:0] fault_addr
);
    localparam logic [HW-1:0] FMT_WORD = {FRAME_FMT, VEC_OFFSET};

    afw_state_t       state, nxt;
    logic [IDX_W-1:0] idx;
    logic [DW-1:0]    sp_r, pc_r, wr_addr;
    logic [HW-1:0]    sr_r, stat_new, half;
    logic             is_word, last, capture;
    afw_src_t         src;

    afw_status_pack u_pack (
        .size     (flt_size),
        .is_write (flt_write),
        .is_code  (flt_code),
        .is_super (flt_super),
        .word     (stat_new)
    );

    afw_frame_seq u_seq (
        .idx     (idx),
        .is_word (is_word),
        .src     (src),
        .last    (last)
    );

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (flt_req) nxt = ST_PUSH;
            ST_PUSH:   if (flt_req) nxt = ST_HALT;
                       else if (last) nxt = ST_FINISH;
            ST_FINISH: nxt = flt_req ? ST_PUSH : ST_IDLE;
            ST_HALT:   nxt = ST_HALT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    assign capture = flt_req && (state == ST_IDLE || state == ST_FINISH);
    assign wr_addr = sp_r - (is_word ? DW'(2) : DW'(4));

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx         <= '0;
            sp_r        <= '0;
            pc_r        <= '0;
            sr_r        <= '0;
            status_word <= '0;
            fault_addr  <= '0;
        end else if (capture) begin
            idx         <= '0;
            sp_r        <= {sp_in[DW-1:1], 1'b0};
            pc_r        <= pc_in;
            sr_r        <= sr_in;
            status_word <= stat_new;
            fault_addr  <= flt_addr;
        end else if (state == ST_PUSH && !flt_req) begin
            idx  <= idx + IDX_W'(1);
            sp_r <= wr_addr;
        end
    end

    // outputs
    always_comb begin
        unique case (src)
            SRC_STAT: half = status_word;
            SRC_FMT:  half = FMT_WORD;
            SRC_SR:   half = sr_r;
            default:  half = '0;
        endcase
        mem_we    = (state == ST_PUSH);
        mem_addr  = wr_addr;
        if (is_word)                mem_wdata = {half, half};
        else if (src == SRC_FADDR)  mem_wdata = fault_addr;
        else if (src == SRC_PC)     mem_wdata = pc_r;
        else                        mem_wdata = '0;
        mem_be    = is_word ? (wr_addr[1] ? 4'b1100 : 4'b0011) : 4'b1111;
        done      = (state == ST_FINISH);
        halt      = (state == ST_HALT);
        sp_out    = sp_r;
    end
endmodule

// File: rtl/afw_frame_chk.sv
module afw_frame_chk
    import afw_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          mem_we,
    input logic [3:0]    mem_be,
    input logic [DW-1:0] sp_out,
    input logic          done,
    input logic          halt,
    input logic [HW-1:0] status_word
);
    // R11
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);
    // R11
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !mem_we);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    done_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_we);
    // R10
    stream_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we) |-> (done || halt));
    // R8
    be_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_be == 4'b1111 || mem_be == 4'b0011 || mem_be == 4'b1100));
    // R6
    sp_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !sp_out[0]);
    // R2
    stat_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> status_word[10]);
endmodule

bind afw_frame_writer afw_frame_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_we      (mem_we),
    .mem_be      (mem_be),
    .sp_out      (sp_out),
    .done        (done),
    .halt        (halt),
    .status_word (status_word)
);

// File: tb/sim_afw_frame_writer.sv
`timescale 1ns/1ps
module sim_afw_frame_writer;

    typedef struct {
        logic [31:0] addr;
        logic [3:0]  be;
        logic [31:0] data;
    } beat_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flt_req = 1'b0;
    logic [31:0] flt_addr = '0;
    logic [1:0]  flt_size = '0;
    logic        flt_write = 1'b0, flt_code = 1'b0, flt_super = 1'b0;
    logic [31:0] sp_in = '0, pc_in = '0;
    logic [15:0] sr_in = '0;
    logic        mem_we, done, halt;
    logic [31:0] mem_addr, mem_wdata, sp_out, fault_addr;
    logic [3:0]  mem_be;
    logic [15:0] status_word;

    int n_cmp = 0, n_bad = 0;
    int pos = 0;
    beat_t       exp_q[$];
    logic [31:0] sp_q[$];

    always #2 clk = ~clk;

    afw_frame_writer u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, expv);
        end
    endtask

    function automatic logic [15:0] exp_stat(input logic [1:0] sz, input bit wr,
                                             input bit cd, input bit su);
        logic [15:0] s;
        s = 16'h0400;
        if (!wr) s |= 16'h0100;
        if (sz == 2'b00) s |= 16'h0020;
        else if (sz == 2'b01) s |= 16'h0040;
        if (su) s |= 16'h0004;
        s |= cd ? 16'h0002 : 16'h0001;
        return s;
    endfunction

    // Scoreboard driver side: expected beats from the frame layout.
    task automatic build_exp(input logic [31:0] a, input logic [1:0] sz, input bit wr,
                             input bit cd, input bit su, input logic [31:0] sp,
                             input logic [15:0] sr, input logic [31:0] pc,
                             input int limit);
        logic [31:0] s;
        logic [15:0] st;
        s  = {sp[31:1], 1'b0};
        st = exp_stat(sz, wr, cd, su);
        for (int i = 0; i < 18; i++) begin
            bit          w;
            logic [31:0] v;
            beat_t       b;
            w = (i >= 10 && i <= 13) || i == 16 || i == 17;
            case (i)
                8, 9, 14: v = a;
                13:       v = {16'h0, st};
                15:       v = pc;
                16:       v = 32'h7008;
                17:       v = {16'h0, sr};
                default:  v = 32'h0;
            endcase
            s = s - (w ? 32'd2 : 32'd4);
            b.addr = s;
            b.be   = w ? (s[1] ? 4'b1100 : 4'b0011) : 4'b1111;
            b.data = w ? {v[15:0], v[15:0]} : v;
            if (i < limit) exp_q.push_back(b);
        end
        if (limit == 18) sp_q.push_back(s);
    endtask

    task automatic run_fault(input logic [31:0] a, input logic [1:0] sz, input bit wr,
                             input bit cd, input bit su, input logic [31:0] sp,
                             input logic [15:0] sr, input logic [31:0] pc);
        build_exp(a, sz, wr, cd, su, sp, sr, pc, 18);
        flt_req = 1'b1; flt_addr = a; flt_size = sz; flt_write = wr;
        flt_code = cd; flt_super = su; sp_in = sp; sr_in = sr; pc_in = pc;
        @(negedge clk);
        flt_req = 1'b0;
        repeat (18) @(negedge clk);
        chk(status_word[10] == 1'b1 && status_word[8] == !wr, "R2", 32'(status_word),
            32'(exp_stat(sz, wr, cd, su)));
        chk(status_word[6:5] == exp_stat(sz, wr, cd, su) >> 5 & 2'b11 ||
            status_word[6:5] == exp_stat(sz, wr, cd, su)[6:5], "R3",
            32'(status_word[6:5]), 32'(exp_stat(sz, wr, cd, su)[6:5]));
        chk(status_word[2:0] == exp_stat(sz, wr, cd, su)[2:0], "R4",
            32'(status_word[2:0]), 32'(exp_stat(sz, wr, cd, su)[2:0]));
        chk(fault_addr == a, "R5", fault_addr, a);
    endtask

    // Scoreboard monitor side.
    always @(negedge clk) begin
        if (!rst_n) begin
            pos = 0;
        end else begin
            if (mem_we) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R11 unexpected write", mem_addr, 32'h0);
                end else begin
                    beat_t e;
                    string r;
                    e = exp_q.pop_front();
                    r = (pos < 10) ? "R7" : (pos < 14) ? "R8" : "R9";
                    chk(mem_addr == e.addr, {r, " addr R6"}, mem_addr, e.addr);
                    chk(mem_be == e.be, {r, " be R8"}, 32'(mem_be), 32'(e.be));
                    chk(mem_wdata == e.data, {r, " data"}, mem_wdata, e.data);
                end
                pos++;
            end
            if (done) begin
                logic [31:0] es;
                es = (sp_q.size() != 0) ? sp_q.pop_front() : 32'hx;
                chk(sp_out === es, "R6 sp_out", sp_out, es);
                chk(pos == 18, "R10 beat count", 32'(pos), 32'd18);
                pos = 0;
            end
        end
    end

    initial begin
        #(4 * 20000);
        chk(1'b0, "watchdog", 32'h0, 32'h0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!mem_we && !done && !halt, "R1 controls", {29'h0, mem_we, done, halt}, 32'h0);
        chk(status_word == 16'h0 && fault_addr == 32'h0, "R1 regs", fault_addr, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // byte read, data, user, odd SP (R3 R4 R6)
        run_fault(32'h0001_2345, 2'b00, 1'b0, 1'b0, 1'b0, 32'h0000_8001, 16'h2704, 32'h0000_1000);
        repeat (2) @(negedge clk);
        // word write, code fetch, supervisor, SP at 2 mod 4 (R8 lanes)
        run_fault(32'hCAFE_0010, 2'b01, 1'b1, 1'b1, 1'b1, 32'h0000_9002, 16'h2000, 32'h0000_2222);
        repeat (2) @(negedge clk);
        // long read, data, supervisor
        run_fault(32'h8000_FFFC, 2'b10, 1'b0, 1'b0, 1'b1, 32'h0001_0000, 16'h2300, 32'hDEAD_BEE0);
        repeat (2) @(negedge clk);
        // size code 11 reads as long (R3); R12 back-to-back in the done cycle
        run_fault(32'h1234_5678, 2'b11, 1'b1, 1'b0, 1'b0, 32'h0002_0006, 16'h0010, 32'h0000_3000);
        run_fault(32'h0BAD_F00D, 2'b01, 1'b0, 1'b1, 1'b0, 32'h0003_0000, 16'h0011, 32'h0000_4000);
        chk(halt == 1'b0, "R12 no halt", 32'(halt), 32'h0);
        repeat (2) @(negedge clk);

        // R11 double fault after four beats
        build_exp(32'h5555_0000, 2'b10, 1'b0, 1'b0, 1'b1, 32'h0004_0000, 16'h2000, 32'h0000_5000, 4);
        flt_req = 1'b1; flt_addr = 32'h5555_0000; flt_size = 2'b10; flt_write = 1'b0;
        flt_code = 1'b0; flt_super = 1'b1; sp_in = 32'h0004_0000; sr_in = 16'h2000;
        pc_in = 32'h0000_5000;
        @(negedge clk);
        flt_req = 1'b0;
        repeat (3) @(negedge clk);
        flt_req = 1'b1; flt_addr = 32'h6666_0000; flt_size = 2'b00;
        @(negedge clk);
        flt_req = 1'b0;
        for (int k = 0; k < 5; k++) begin
            chk(halt == 1'b1 && mem_we == 1'b0, "R11 halt", {30'h0, halt, mem_we}, 32'h2);
            @(negedge clk);
        end
        chk(fault_addr == 32'h5555_0000, "R11 fault_addr kept", fault_addr, 32'h5555_0000);
        chk(exp_q.size() == 0, "R11 beats before halt", 32'(exp_q.size()), 32'h0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(halt == 1'b0, "R11 cleared by reset", 32'(halt), 32'h0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule